// File: doc/BRIEF.md
# Serial Port Register Bank with Interrupt Logic

This block is the software-visible face of a serial port. A host reaches it over a simple word-addressed bus: a read strobe, a write strobe, a 12-bit byte offset and 32-bit data. Reads are combinational in the same cycle as the strobe, and writes take effect at the clock edge. The low two offset bits are ignored, so every register is decoded on its word index.

The bank holds the configuration words that the transmitter, receiver and baud generator need, and brings them out on dedicated output ports. It reports line status and merges two interrupt sources, transmit and receive, into raw, mask and masked views that drive one level-sensitive interrupt line. A write to the data word emits the byte on a one-cycle transmit strobe. A read of the data word pops the external receive storage through a pop-and-data interface. The top eight words of the 4 KB window return fixed identification bytes.

Top module: `uart_regbank`

## Requirements
- R1: Word indices 8, 9, 10, 11, 12, 13 and 18 hold configuration fields 8, 16, 6, 8, 16, 6 and 3 bits wide. A write stores the low bits of the written word. A read returns the stored field zero-extended, and each field also drives its own output port. The bits below bit 2 of the offset play no part in the decode.
- R2: A read of byte offsets 0xFE0 to 0xFFC returns one byte per word, zero-extended, in ascending order: 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R3: After reset the field at word 13 reads 0x12, the field at word 12 reads 0x300, the other fields read 0, the raw and mask words read 0, the interrupt line is low, and the status word at index 6 reads 0x90 while the receive storage reports neither data nor full.
- R4: A write to word 0 raises tx_strobe for exactly the following cycle, with tx_byte equal to bits 7:0 of the written word, and sets the transmit interrupt (bit 5) in the raw word at index 15.
- R5: The mask word (index 14) stores only bits 5 and 4. The masked word (index 16) reads raw AND mask. irq is high exactly when the masked value is nonzero, and follows a mask write from the next clock edge.
- R6: A write to word 17 clears each raw bit whose position is set in the written value. Raw bits not named in the write keep their value.
- R7: A pulse on rx_event sets the receive interrupt (bit 4) in the raw word. When it coincides with a clear of that bit, whether by a write to word 17 or by a data-word pop, the bit stays set.
- R8: A read of word 0 while rx_avail is high returns rx_data zero-extended, raises rx_pop in that same cycle and clears raw bit 4. While rx_avail is low, the same read returns 0 and raises no pop.
- R9: The status word reads bit 7 as 1 (transmit empty) and bit 5 as 0 (transmit not full). Bit 4 reads as the inverse of rx_avail and bit 6 as rx_full. All other bits read 0.
- R10: Reads of unmapped words return 0. Writes to unmapped words and to the read-only words (status, raw, masked, identification) change no register.

Top module port order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| rx_data | input | 8 | Head byte of the receive storage |
| rx_avail | input | 1 | Receive storage holds data |
| rx_full | input | 1 | Receive storage is full |
| rx_event | input | 1 | Receive interrupt request pulse |
| rx_pop | output | 1 | Removes the head byte from the receive storage |
| tx_byte | output | 8 | Byte to transmit |
| tx_strobe | output | 1 | One-cycle transmit request |
| irq | output | 1 | Level interrupt |
| cfg_ilpr | output | 8 | Infrared low-power divisor |
| cfg_ibrd | output | 16 | Integer baud divisor |
| cfg_fbrd | output | 6 | Fractional baud divisor |
| cfg_lcr | output | 8 | Line control |
| cfg_ctrl | output | 16 | Control |
| cfg_ifls | output | 6 | FIFO level select |
| cfg_dma | output | 3 | DMA control |

## Verification
The receive interrupt bit has one setter, rx_event, and two clearers: a write to the clear word and a pop through a data-word read. Both clearers can land in the same cycle as a set. The bench provokes each collision by pulsing rx_event on the same clock edge as the clearing bus access. It then reads the raw word to judge that the set won, and that the transmit bit alongside it did not change. It also checks that a normal clear afterwards still removes the bit.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;

  localparam int WORD_DATA  = 0;
  localparam int WORD_FLAG  = 6;
  localparam int WORD_MASK  = 14;
  localparam int WORD_RAW   = 15;
  localparam int WORD_MIS   = 16;
  localparam int WORD_CLR   = 17;

  localparam int NCFG = 7;
  // ilpr, ibrd, fbrd, lcr, ctrl, ifls, dma
  localparam int CFG_WORD  [NCFG] = '{8, 9, 10, 11, 12, 13, 18};
  localparam int CFG_WIDTH [NCFG] = '{8, 16, 6, 8, 16, 6, 3};
  localparam int CFG_RST   [NCFG] = '{0, 0, 0, 0, 32'h300, 32'h12, 0};

  // interrupt bit positions in the bus word
  localparam int IRQ_RX_BIT = 4;
  localparam int IRQ_TX_BIT = 5;

  // fixed identification bytes, index 0 is the lowest word
  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h11;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h14;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  // raw interrupt update: set wins over clear; bit1 = TX, bit0 = RX
  function automatic logic [1:0] raw_next(input logic [1:0] cur,
                                          input logic [1:0] set,
                                          input logic [1:0] clr);
    raw_next = (cur & ~clr) | set;
  endfunction

  // status word from receive storage state
  function automatic logic [31:0] flag_word(input logic avail, input logic full);
    flag_word = 32'h80 | (avail ? 32'h0 : 32'h10) | (full ? 32'h40 : 32'h0);
  endfunction

endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
  import uart_rb_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_id,
  output logic [2:0]        id_idx,
  output logic              sel_data,
  output logic              sel_flag,
  output logic              sel_mask,
  output logic              sel_raw,
  output logic              sel_mis,
  output logic              sel_clr,
  output logic [NCFG-1:0]   sel_cfg
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic              unused_lo;

  assign widx      = addr[ADDR_W-1:2];
  assign unused_lo = ^addr[1:0];
  assign is_id     = &addr[ADDR_W-1:5];
  assign id_idx    = addr[4:2];

  always_comb begin
    sel_data = !is_id && (widx == WIDX_W'(WORD_DATA));
    sel_flag = !is_id && (widx == WIDX_W'(WORD_FLAG));
    sel_mask = !is_id && (widx == WIDX_W'(WORD_MASK));
    sel_raw  = !is_id && (widx == WIDX_W'(WORD_RAW));
    sel_mis  = !is_id && (widx == WIDX_W'(WORD_MIS));
    sel_clr  = !is_id && (widx == WIDX_W'(WORD_CLR));
    for (int i = 0; i < NCFG; i++) begin
      sel_cfg[i] = !is_id && (widx == WIDX_W'(CFG_WORD[i]));
    end
  end

endmodule

// File: rtl/uart_rb_cfgreg.sv
module uart_rb_cfgreg #(
  parameter int          WIDTH = 8,
  parameter logic [31:0] RST   = 32'h0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST[WIDTH-1:0];
    else if (we) q <= wdata;
  end

  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));

endmodule

// File: rtl/uart_rb_irq.sv
module uart_rb_irq
  import uart_rb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_set,
  input  logic       rx_set,
  input  logic       rx_drop,
  input  logic       mask_we,
  input  logic       clr_we,
  input  logic [1:0] wbits,
  output logic [1:0] raw_o,
  output logic [1:0] mask_o,
  output logic       irq
);
  logic [1:0] raw_q, mask_q, clr_vec, set_vec;

  assign set_vec = {tx_set, rx_set};
  assign clr_vec = (clr_we ? wbits : 2'b00) | {1'b0, rx_drop};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= 2'b00;
      mask_q <= 2'b00;
    end else begin
      raw_q <= raw_next(raw_q, set_vec, clr_vec);
      if (mask_we) mask_q <= wbits;
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign irq    = |(raw_q & mask_q);

  assert_tx_raw_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_set |=> raw_q[1]);
  assert_rx_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_set |=> raw_q[0]);
  assert_w1c_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && wbits[1] && !tx_set) |=> !raw_q[1]);
  assert_raw_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_set && !rx_set && !clr_we && !rx_drop) |=> $stable(raw_q));
  assert_mask_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && wbits == 2'b00) |=> !irq);

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_rb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [7:0]        rx_data,
  input  logic              rx_avail,
  input  logic              rx_full,
  input  logic              rx_event,
  output logic              rx_pop,
  output logic [7:0]        tx_byte,
  output logic              tx_strobe,
  output logic              irq,
  output logic [7:0]        cfg_ilpr,
  output logic [15:0]       cfg_ibrd,
  output logic [5:0]        cfg_fbrd,
  output logic [7:0]        cfg_lcr,
  output logic [15:0]       cfg_ctrl,
  output logic [5:0]        cfg_ifls,
  output logic [2:0]        cfg_dma
);
  logic            is_id;
  logic [2:0]      id_idx;
  logic            sel_data, sel_flag, sel_mask, sel_raw, sel_mis, sel_clr;
  logic [NCFG-1:0] sel_cfg;
  logic [DATA_W-1:0] cfg_word [NCFG];
  logic [1:0]      raw_bits, mask_bits;
  logic            data_wr, data_pop;
  logic            unused_hi;

  assign unused_hi = ^bus_wdata[DATA_W-1:16];

  uart_rb_decode #(.ADDR_W(ADDR_W)) dec_i (
    .addr(bus_addr), .is_id(is_id), .id_idx(id_idx),
    .sel_data(sel_data), .sel_flag(sel_flag), .sel_mask(sel_mask),
    .sel_raw(sel_raw), .sel_mis(sel_mis), .sel_clr(sel_clr),
    .sel_cfg(sel_cfg)
  );

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    logic [CFG_WIDTH[g]-1:0] q_g;
    uart_rb_cfgreg #(.WIDTH(CFG_WIDTH[g]), .RST(CFG_RST[g])) reg_i (
      .clk(clk), .rst_n(rst_n), .we(bus_wr && sel_cfg[g]),
      .wdata(bus_wdata[CFG_WIDTH[g]-1:0]), .q(q_g)
    );
    assign cfg_word[g] = {{(DATA_W-CFG_WIDTH[g]){1'b0}}, q_g};
  end

  assign cfg_ilpr = cfg_word[0][7:0];
  assign cfg_ibrd = cfg_word[1][15:0];
  assign cfg_fbrd = cfg_word[2][5:0];
  assign cfg_lcr  = cfg_word[3][7:0];
  assign cfg_ctrl = cfg_word[4][15:0];
  assign cfg_ifls = cfg_word[5][5:0];
  assign cfg_dma  = cfg_word[6][2:0];

  assign data_wr  = bus_wr && sel_data;
  assign data_pop = bus_rd && sel_data && rx_avail;
  assign rx_pop   = data_pop;

  uart_rb_irq irq_i (
    .clk(clk), .rst_n(rst_n), .tx_set(data_wr), .rx_set(rx_event),
    .rx_drop(data_pop), .mask_we(bus_wr && sel_mask),
    .clr_we(bus_wr && sel_clr),
    .wbits(bus_wdata[IRQ_TX_BIT:IRQ_RX_BIT]),
    .raw_o(raw_bits), .mask_o(mask_bits), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_strobe <= 1'b0;
      tx_byte   <= 8'h00;
    end else begin
      tx_strobe <= data_wr;
      if (data_wr) tx_byte <= bus_wdata[7:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (is_id)         bus_rdata = DATA_W'(id_byte(id_idx));
      else if (sel_data) bus_rdata = rx_avail ? DATA_W'(rx_data) : '0;
      else if (sel_flag) bus_rdata = flag_word(rx_avail, rx_full);
      else if (sel_mask) bus_rdata = DATA_W'({mask_bits, 4'b0});
      else if (sel_raw)  bus_rdata = DATA_W'({raw_bits, 4'b0});
      else if (sel_mis)  bus_rdata = DATA_W'({raw_bits & mask_bits, 4'b0});
      else begin
        for (int i = 0; i < NCFG; i++)
          if (sel_cfg[i]) bus_rdata = cfg_word[i];
      end
    end
  end

  assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({is_id, sel_data, sel_flag, sel_mask, sel_raw, sel_mis, sel_clr, sel_cfg}));
  assert_tx_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_data) |=> (tx_strobe && tx_byte == $past(bus_wdata[7:0])));
  assert_pop_needs_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> (rx_avail && bus_rd));
  assert_irq_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel_mis) |-> (irq == (bus_rdata != '0)));

endmodule

// File: tb/uart_regbank_tb_top.sv
module uart_regbank_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rd = 0, bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  rx_data = '0;
  logic rx_avail = 0, rx_full = 0, rx_event = 0;
  logic rx_pop, tx_strobe, irq;
  logic [7:0] tx_byte, cfg_ilpr, cfg_lcr;
  logic [15:0] cfg_ibrd, cfg_ctrl;
  logic [5:0] cfg_fbrd, cfg_ifls;
  logic [2:0] cfg_dma;

  int n_chk = 0, n_fail = 0;
  logic done = 0;
  logic [31:0] rd;
  logic pop_seen;

  always #2.5 clk = ~clk;

  uart_regbank dut_i (
    .clk, .rst_n, .bus_rd, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .rx_data, .rx_avail, .rx_full, .rx_event, .rx_pop, .tx_byte, .tx_strobe,
    .irq, .cfg_ilpr, .cfg_ibrd, .cfg_fbrd, .cfg_lcr, .cfg_ctrl, .cfg_ifls, .cfg_dma
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic ev = 0);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d; rx_event = ev;
    @(negedge clk);
    bus_wr = 0; rx_event = 0;
  endtask

  task automatic rdw(input logic [11:0] a, output logic [31:0] d, input logic ev = 0);
    @(negedge clk);
    bus_rd = 1; bus_addr = a; rx_event = ev;
    #1 d = bus_rdata; pop_seen = rx_pop;
    @(negedge clk);
    bus_rd = 0; rx_event = 0;
  endtask

  // {write, addr, wdata, expected read, requirement number}
  localparam int NV = 29;
  localparam logic [80:0] VEC [NV] = '{
    {1'b1, 12'h020, 32'hFFFF_FFAB, 32'h0,   4'd1},
    {1'b0, 12'h020, 32'h0,         32'hAB,  4'd1},
    {1'b1, 12'h024, 32'h1234_5678, 32'h0,   4'd1},
    {1'b0, 12'h024, 32'h0,         32'h5678,4'd1},
    {1'b1, 12'h028, 32'hFF,        32'h0,   4'd1},
    {1'b0, 12'h028, 32'h0,         32'h3F,  4'd1},
    {1'b1, 12'h02C, 32'h70,        32'h0,   4'd1},
    {1'b0, 12'h02C, 32'h0,         32'h70,  4'd1},
    {1'b1, 12'h030, 32'hFFFF_0301, 32'h0,   4'd1},
    {1'b0, 12'h030, 32'h0,         32'h301, 4'd1},
    {1'b1, 12'h034, 32'h2D,        32'h0,   4'd1},
    {1'b0, 12'h034, 32'h0,         32'h2D,  4'd1},
    {1'b1, 12'h048, 32'hD,         32'h0,   4'd1},
    {1'b0, 12'h048, 32'h0,         32'h5,   4'd1},
    {1'b0, 12'h032, 32'h0,         32'h301, 4'd1},
    {1'b0, 12'hFE0, 32'h0,         32'h11,  4'd2},
    {1'b0, 12'hFE4, 32'h0,         32'h10,  4'd2},
    {1'b0, 12'hFE8, 32'h0,         32'h14,  4'd2},
    {1'b0, 12'hFEC, 32'h0,         32'h00,  4'd2},
    {1'b0, 12'hFF0, 32'h0,         32'h0D,  4'd2},
    {1'b0, 12'hFF4, 32'h0,         32'hF0,  4'd2},
    {1'b0, 12'hFF8, 32'h0,         32'h05,  4'd2},
    {1'b0, 12'hFFC, 32'h0,         32'hB1,  4'd2},
    {1'b1, 12'h004, 32'hFFFF_FFFF, 32'h0,   4'd10},
    {1'b0, 12'h004, 32'h0,         32'h0,   4'd10},
    {1'b0, 12'h030, 32'h0,         32'h301, 4'd10},
    {1'b1, 12'h018, 32'hFFFF_FFFF, 32'h0,   4'd10},
    {1'b0, 12'h018, 32'h0,         32'h90,  4'd10},
    {1'b0, 12'h0FC, 32'h0,         32'h0,   4'd10}
  };

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R3 reset state
    rdw(12'h034, rd); check("R3 ifls", rd, 32'h12);
    rdw(12'h030, rd); check("R3 ctrl", rd, 32'h300);
    rdw(12'h018, rd); check("R3 flags", rd, 32'h90);
    rdw(12'h03C, rd); check("R3 raw", rd, 32'h0);
    rdw(12'h038, rd); check("R3 mask", rd, 32'h0);
    rdw(12'h024, rd); check("R3 ibrd", rd, 32'h0);
    check("R3 irq", {31'b0, irq}, 32'h0);
    check("R3 tx_strobe", {31'b0, tx_strobe}, 32'h0);

    // table walk: R1, R2, R10
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][80]) wr(VEC[i][79:68], VEC[i][67:36]);
      else begin
        rdw(VEC[i][79:68], rd);
        check($sformatf("R%0d vec%0d", VEC[i][3:0], i), rd, VEC[i][35:4]);
      end
    end
    check("R1 cfg_ctrl port", {16'b0, cfg_ctrl}, 32'h301);
    check("R1 cfg_ibrd port", {16'b0, cfg_ibrd}, 32'h5678);

    // R4 transmit write
    @(negedge clk); bus_wr = 1; bus_addr = 12'h000; bus_wdata = 32'h1A5;
    @(negedge clk); bus_wr = 0;
    check("R4 strobe high", {31'b0, tx_strobe}, 32'h1);
    check("R4 byte", {24'b0, tx_byte}, 32'hA5);
    @(negedge clk);
    check("R4 strobe one cycle", {31'b0, tx_strobe}, 32'h0);
    rdw(12'h03C, rd); check("R4 raw tx", rd, 32'h20);
    check("R5 irq masked off", {31'b0, irq}, 32'h0);

    // R5 mask
    wr(12'h038, 32'hFFFF_FFFF);
    check("R5 irq after mask", {31'b0, irq}, 32'h1);
    rdw(12'h038, rd); check("R5 mask bits", rd, 32'h30);
    rdw(12'h040, rd); check("R5 masked", rd, 32'h20);

    // R6 clear
    wr(12'h044, 32'h10);
    rdw(12'h03C, rd); check("R6 untouched bit", rd, 32'h20);
    wr(12'h044, 32'h20);
    rdw(12'h03C, rd); check("R6 cleared", rd, 32'h0);
    check("R6 irq low", {31'b0, irq}, 32'h0);

    // R10 write to raw word ignored
    wr(12'h03C, 32'h30);
    rdw(12'h03C, rd); check("R10 raw not writable", rd, 32'h0);

    // R7 receive event and collisions
    @(negedge clk); rx_event = 1; @(negedge clk); rx_event = 0;
    rdw(12'h03C, rd); check("R7 rx set", rd, 32'h10);
    check("R7 irq", {31'b0, irq}, 32'h1);
    wr(12'h000, 32'h0);              // also set TX
    wr(12'h044, 32'h10, 1'b1);       // clear RX while event: set wins
    rdw(12'h03C, rd); check("R7 set beats clear", rd, 32'h30);
    wr(12'h044, 32'h30);
    rdw(12'h03C, rd); check("R7 later clear", rd, 32'h0);

    // R8 data pop
    rx_avail = 1; rx_data = 8'h3C;
    wr(12'h044, 32'h0, 1'b1);
    rdw(12'h000, rd); check("R8 data", rd, 32'h3C);
    check("R8 pop", {31'b0, pop_seen}, 32'h1);
    rdw(12'h03C, rd); check("R8 pop clears rx", rd, 32'h0);
    rdw(12'h000, rd, 1'b1);
    rdw(12'h03C, rd); check("R7 set beats pop", rd, 32'h10);

    // R9 flags
    rx_full = 1;
    rdw(12'h018, rd); check("R9 avail full", rd, 32'hC0);
    rx_full = 0; rx_avail = 0;
    rdw(12'h018, rd); check("R9 empty", rd, 32'h90);
    rdw(12'h000, rd); check("R8 empty read", rd, 32'h0);
    check("R8 no pop", {31'b0, pop_seen}, 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule